// File: doc/BRIEF.md
# EEPROM Configuration Loader

This block fetches an adapter's start-up configuration from a serial EEPROM. It does not drive the serial bus itself. A separate reader does that, and this block talks to it through a one-byte read handshake. The loader places an offset on `rd_addr` and pulses `rd_req`. It then waits until the reader returns the byte with `rd_valid`.

A load is started by a `start` pulse. The pulse is accepted only when the adapter's chip reset has been released (`chip_ready` high) and no load is already in progress. The loader then performs eight reads in a fixed order:

1. the ring-speed byte;
2. the adapter-memory-size byte;
3. six station-address bytes taken from consecutive offsets.

It decodes these into a rate-select control value, a memory size in kilobytes, and a 48-bit station address. `done` is pulsed when the last byte has been stored. The decoded outputs keep their values until the next accepted start.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: After synchronous reset, `rd_req`, `done`, `rate_ctrl`, `mem_kb` and `station_addr` are all zero.
- R2: A `start` pulse while `chip_ready` is low is ignored: no read request follows and the outputs keep their values.
- R3: A load issues exactly eight requests, in this address order: `SPEED_OFS`, then `SIZE_OFS`, then `STN_BASE`+0 through `STN_BASE`+5.
- R4: Only one read is outstanding at a time. `rd_req` is a one-cycle pulse and stays low until `rd_valid` arrives. The next request appears in the cycle after the `rd_valid` cycle. The first request appears in the cycle after `start` is accepted.
- R5: `rate_ctrl` bit 0 is 1 (slow, 4 Mbps) when the speed byte is nonzero, and 0 (16 Mbps) when it is zero. Bits 7:1 are always 0.
- R6: `mem_kb` equals the size byte multiplied by 128.
- R7: The byte read from `STN_BASE`+i is placed at `station_addr[8*i+7:8*i]`, for i = 0 to 5.
- R8: `done` is high for exactly one cycle, in the cycle after the `rd_valid` of the sixth station byte.
- R9: Accepting `start` clears `rate_ctrl`, `mem_kb` and `station_addr` to zero. Apart from that, the outputs hold their values. In particular, `rd_valid` arriving while no request is outstanding changes nothing.
- R10: A `start` pulse during a load is ignored, and the load continues with its remaining addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a load |
| chip_ready | input | 1 | High once the adapter chip reset has been released |
| rd_req | output | 1 | One-cycle read request to the serial reader |
| rd_addr | output | ADDR_W | EEPROM offset of the requested byte |
| rd_data | input | 8 | Byte returned by the reader |
| rd_valid | input | 1 | `rd_data` is valid this cycle |
| done | output | 1 | Load complete pulse |
| rate_ctrl | output | 8 | Rate-select control value; bit 0 selects the slow rate |
| mem_kb | output | 15 | Adapter memory size in kilobytes |
| station_addr | output | 48 | Station address, byte i at bits 8i+7:8i |

## Verification
Two situations are hard to reach from the ports:

- a second `start` arriving while a read is still outstanding;
- a `rd_valid` arriving when nothing was requested.

The stimulus creates the first by stretching the reader's latency and pulsing `start` inside that wait, and creates the second by driving `rd_valid` while the loader is idle. In both cases the address order and the held outputs are then compared against the expected values. The speed decode is exercised with zero, one, the top bit alone and all-ones.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int BYTE_W       = 8;
    localparam int STN_BYTES    = 6;
    localparam int FIELD_CNT    = 2 + STN_BYTES;
    localparam int STEP_W       = $clog2(FIELD_CNT);
    localparam int SIZE_SHIFT   = 7;
    localparam int KB_W         = BYTE_W + SIZE_SHIFT;
    localparam int STN_W        = STN_BYTES * BYTE_W;
    localparam int IDX_W        = $clog2(STN_BYTES);

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_REQ  = 2'd1,
        LD_WAIT = 2'd2
    } ld_state_e;

    typedef enum logic [1:0] {
        FLD_SPEED   = 2'd0,
        FLD_SIZE    = 2'd1,
        FLD_STATION = 2'd2
    } fld_kind_e;

    typedef struct packed {
        fld_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } fld_sel_t;

    typedef struct packed {
        logic               slow;
        logic [KB_W-1:0]    kb;
        logic [STN_W-1:0]   stn;
    } cfg_t;

    function automatic fld_sel_t step_to_field(input logic [STEP_W-1:0] step);
        fld_sel_t f;
        f.idx  = '0;
        if (step == STEP_W'(0)) begin
            f.kind = FLD_SPEED;
        end else if (step == STEP_W'(1)) begin
            f.kind = FLD_SIZE;
        end else begin
            f.kind = FLD_STATION;
            f.idx  = IDX_W'(step - STEP_W'(2));
        end
        return f;
    endfunction

    function automatic logic speed_is_slow(input logic [BYTE_W-1:0] b);
        return |b;
    endfunction

    function automatic logic [KB_W-1:0] scale_size(input logic [BYTE_W-1:0] b);
        return {b, {SIZE_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  SPEED_OFS = 8'h03,
    parameter logic [7:0]  SIZE_OFS  = 8'h05,
    parameter logic [7:0]  STN_BASE  = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              chip_ready,
    input  logic              rd_valid,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              clr,
    output logic              cap_en,
    output fld_sel_t          cap_sel,
    output logic              done
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FIELD_CNT - 1);

    ld_state_e          st_q;
    logic [STEP_W-1:0]  step_q;
    logic               done_q;
    logic               accept;
    fld_sel_t           cur;

    assign accept  = (st_q == LD_IDLE) && start && chip_ready;
    assign clr     = accept;
    assign rd_req  = (st_q == LD_REQ);
    assign cur     = step_to_field(step_q);
    assign cap_en  = (st_q == LD_WAIT) && rd_valid;
    assign cap_sel = cur;
    assign done    = done_q;

    always_comb begin
        unique case (cur.kind)
            FLD_SPEED: rd_addr = ADDR_W'(SPEED_OFS);
            FLD_SIZE:  rd_addr = ADDR_W'(SIZE_OFS);
            default:   rd_addr = ADDR_W'(STN_BASE) + ADDR_W'(cur.idx);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LD_IDLE;
            step_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                LD_IDLE: begin
                    if (accept) begin
                        st_q   <= LD_REQ;
                        step_q <= '0;
                    end
                end
                LD_REQ: st_q <= LD_WAIT;
                LD_WAIT: begin
                    if (rd_valid) begin
                        if (step_q == LAST_STEP) begin
                            st_q   <= LD_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st_q   <= LD_REQ;
                            step_q <= step_q + STEP_W'(1);
                        end
                    end
                end
                default: st_q <= LD_IDLE;
            endcase
        end
    end

    assert_req_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_capture_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(cap_en));

endmodule

// File: rtl/cfgld_store.sv
module cfgld_store
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap_en,
    input  fld_sel_t          cap_sel,
    input  logic [BYTE_W-1:0] cap_data,
    output cfg_t              cfg
);

    logic            slow_q;
    logic [KB_W-1:0] kb_q;
    logic [STN_W-1:0] stn_w;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slow_q <= 1'b0;
            kb_q   <= '0;
        end else if (cap_en) begin
            if (cap_sel.kind == FLD_SPEED) slow_q <= speed_is_slow(cap_data);
            if (cap_sel.kind == FLD_SIZE)  kb_q   <= scale_size(cap_data);
        end
    end

    for (genvar g = 0; g < STN_BYTES; g++) begin : g_stn
        logic [BYTE_W-1:0] b_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                b_q <= '0;
            end else if (cap_en && cap_sel.kind == FLD_STATION
                         && cap_sel.idx == IDX_W'(g)) begin
                b_q <= cap_data;
            end
        end
        assign stn_w[g*BYTE_W +: BYTE_W] = b_q;
    end

    assign cfg.slow = slow_q;
    assign cfg.kb   = kb_q;
    assign cfg.stn  = stn_w;

    assert_hold_without_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !clr) |=> ($stable(cfg.kb) && $stable(cfg.stn) && $stable(cfg.slow)));

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  SPEED_OFS = 8'h03,
    parameter logic [7:0]  SIZE_OFS  = 8'h05,
    parameter logic [7:0]  STN_BASE  = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              chip_ready,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic              rd_valid,
    output logic              done,
    output logic [7:0]        rate_ctrl,
    output logic [14:0]       mem_kb,
    output logic [47:0]       station_addr
);

    logic     clr;
    logic     cap_en;
    fld_sel_t cap_sel;
    cfg_t     cfg;

    cfgld_seq #(
        .ADDR_W    (ADDR_W),
        .SPEED_OFS (SPEED_OFS),
        .SIZE_OFS  (SIZE_OFS),
        .STN_BASE  (STN_BASE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .chip_ready (chip_ready),
        .rd_valid   (rd_valid),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .clr        (clr),
        .cap_en     (cap_en),
        .cap_sel    (cap_sel),
        .done       (done)
    );

    cfgld_store u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .cap_en   (cap_en),
        .cap_sel  (cap_sel),
        .cap_data (rd_data),
        .cfg      (cfg)
    );

    assign rate_ctrl    = {7'b0, cfg.slow};
    assign mem_kb       = cfg.kb;
    assign station_addr = cfg.stn;

    assert_no_req_with_done_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req);

endmodule

// File: tb/eeprom_cfg_loader_test.sv
module eeprom_cfg_loader_test;

    localparam logic [7:0] P_SPD  = 8'h03;
    localparam logic [7:0] P_SIZE = 8'h05;
    localparam logic [7:0] P_BASE = 8'h10;

    // {speed byte, size byte, station 48b (byte0 in low bits), latency}
    localparam int NVEC = 5;
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h00, 8'h04, 48'h0605_0403_0201, 8'd0},
        {8'h01, 8'hFF, 48'hA1B2_C3D4_E5F6, 8'd1},
        {8'h80, 8'h00, 48'hFFFF_FFFF_FFFF, 8'd3},
        {8'hFF, 8'h01, 48'h0000_0000_0000, 8'd2},
        {8'h00, 8'h80, 48'h1357_9BDF_0246, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        chip_ready = 1'b0;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic [7:0]  rd_data = 8'h00;
    logic        rd_valid = 1'b0;
    logic        done;
    logic [7:0]  rate_ctrl;
    logic [14:0] mem_kb;
    logic [47:0] station_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    eeprom_cfg_loader #(
        .ADDR_W(8), .SPEED_OFS(P_SPD), .SIZE_OFS(P_SIZE), .STN_BASE(P_BASE)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .chip_ready(chip_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .rate_ctrl(rate_ctrl), .mem_kb(mem_kb), .station_addr(station_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag, input logic [7:0] rate, input logic [14:0] kb, input logic [47:0] stn);
        chk(rate_ctrl == rate, {tag, " rate_ctrl"}, 64'(rate_ctrl), 64'(rate));
        chk(mem_kb == kb, {tag, " mem_kb"}, 64'(mem_kb), 64'(kb));
        chk(station_addr == stn, {tag, " station_addr"}, 64'(station_addr), 64'(stn));
    endtask

    // Caller is just after a negedge. Runs one full load.
    task automatic do_load(input logic [7:0] spd, input logic [7:0] sz,
                           input logic [47:0] stn, input int lat, input bit poke);
        logic [7:0] exp_addr;
        logic [7:0] b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            exp_addr = (k == 0) ? P_SPD : (k == 1) ? P_SIZE : P_BASE + 8'(k - 2);
            b = (k == 0) ? spd : (k == 1) ? sz : stn[8*(k-2) +: 8];
            chk(rd_req == 1'b1, "R4 request present", 64'(rd_req), 64'd1);
            chk(rd_addr == exp_addr, "R3 request address", 64'(rd_addr), 64'(exp_addr));
            if (k == 0) chk_outs("R9 cleared on start", 8'h00, 15'd0, 48'd0);
            chk(done == 1'b0, "R8 no early done", 64'(done), 64'd0);
            @(negedge clk);
            for (int w = 0; w < lat; w++) begin
                chk(rd_req == 1'b0, "R4 one outstanding", 64'(rd_req), 64'd0);
                if (poke && w == 0 && k == 3) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            chk(rd_req == 1'b0, "R4 no request before valid", 64'(rd_req), 64'd0);
            rd_valid = 1'b1;
            rd_data  = b;
            @(negedge clk);
            rd_valid = 1'b0;
            rd_data  = 8'h5A;
        end
        chk(done == 1'b1, "R8 done pulse", 64'(done), 64'd1);
        chk(rate_ctrl == {7'b0, (spd != 8'h00)}, "R5 rate decode", 64'(rate_ctrl), 64'(spd != 8'h00));
        chk(mem_kb == 15'(sz) * 15'd128, "R6 size scale", 64'(mem_kb), 64'(15'(sz) * 15'd128));
        chk(station_addr == stn, "R7 station order", 64'(station_addr), 64'(stn));
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'd0);
        chk(rd_req == 1'b0, "R3 only eight requests", 64'(rd_req), 64'd0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(rd_req == 1'b0, "R1 reset rd_req", 64'(rd_req), 64'd0);
        chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
        chk_outs("R1 reset", 8'h00, 15'd0, 48'd0);

        // R2: start ignored while chip reset is held
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(rd_req == 1'b0, "R2 no request without chip_ready", 64'(rd_req), 64'd0);
            @(negedge clk);
        end
        chip_ready = 1'b1;

        // table of loads
        for (int v = 0; v < NVEC; v++) begin
            do_load(VEC[v][71:64], VEC[v][63:56], VEC[v][55:8], int'(VEC[v][7:0]), 1'b0);
            @(negedge clk);
        end

        // R9: stray valid while idle changes nothing
        rd_valid = 1'b1;
        rd_data  = 8'hEE;
        @(negedge clk);
        rd_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R9 stray valid no done", 64'(done), 64'd0);
        chk_outs("R9 stray valid ignored", 8'h00, 15'h4000, 48'h1357_9BDF_0246);

        // R2 again after a load: outputs held
        chip_ready = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(rd_req == 1'b0, "R2 start ignored", 64'(rd_req), 64'd0);
        chk_outs("R2 outputs held", 8'h00, 15'h4000, 48'h1357_9BDF_0246);
        chip_ready = 1'b1;

        // R10: start during a load is ignored
        do_load(8'h01, 8'h02, 48'hCAFE_0000_BEEF, 2, 1'b1);
        @(negedge clk);
        chk(rd_req == 1'b0, "R10 no restart", 64'(rd_req), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule